// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations for a memory-management unit. Each line holds a 4 KB virtual page number (virtual address bits [31:12]), the address-space ID of the context that owns it, a physical frame number and a 3-bit permission field. A requester presents an ASID and a 32-bit virtual address on the lookup port. In the same cycle it gets back a hit flag, the frame and the permissions. A page-walk engine outside this block writes translations in through the fill port. Software-style maintenance reaches the block as single 32-bit invalidation command words.

A command chooses one of three scopes: every line, one 4 MB section (virtual address bits [31:22]) or one 16 KB group (virtual address bits [31:14]). Bit 31 can narrow the command to a single ASID. Where that ASID field sits depends on whether the block is built for 128 address spaces or for 4. A configuration input sets how many lines are in service. This lets a deployment trade capacity for power, or fence off lines while debugging. Replacement is round-robin within the lines in service.

Top module: `asid_tlb`

## Requirements
- R1: After reset every line is invalid, so every lookup misses. On any miss, `lk_hit`, `lk_pfn` and `lk_perm` are all zero.
- R2: A lookup hits, in the same cycle, when a valid line in service holds a tag equal to `lk_vaddr[31:12]` and an ASID equal to `lk_asid`. The ASID compare uses all 7 bits, or only bits [1:0] when `NARROW_ASID` is 1. A hit returns that line's frame and permissions. A fill becomes visible to lookups from the next cycle.
- R3: A fill whose tag and ASID match no line in service goes to the line named by a round-robin pointer. After reset the pointer names line 0. Each such allocation moves it one line forward, and it wraps to 0 when it reaches the active-line count. A pointer at or above the count selects line 0.
- R4: A fill whose tag and ASID match a valid line in service overwrites that line and does not move the pointer. Any other valid line with the same tag and ASID is cleared. At most one line ever hits a lookup.
- R5: Only lines whose index is below the active-line count can hit or be allocated. A count above `NUM_LINES` acts as `NUM_LINES`. A count of zero makes every lookup miss and drops fills. Invalidation reaches all lines, in service or not.
- R6: An invalidation command with bits [1:0] = 0 clears every line that the ASID qualifier admits. The lines are gone from the cycle after the command.
- R7: A command with bits [1:0] = 2 clears the admitted lines whose virtual address bits [31:22] equal command bits [19:10].
- R8: A command with bits [1:0] = 3 clears the admitted lines whose virtual address bits [31:14] equal command bits [19:2].
- R9: A command with bits [1:0] = 1 changes no line.
- R10: When command bit 31 is 0, lines of every ASID are admitted. When it is 1, only lines whose ASID equals the command's ASID field are admitted. That field is bits [30:24] in the 7-bit build and bits [30:29] in the 2-bit build.
- R11: A lookup in the same cycle as an invalidation command misses on any line that the command clears. Other lines hit normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_active | input | CNT_W | Number of lines in service |
| lk_asid | input | 7 | Lookup address-space ID |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Frame number of the hitting line, zero on a miss |
| lk_perm | output | PERM_W | Permissions of the hitting line, zero on a miss |
| fill_en | input | 1 | Write a translation this cycle |
| fill_asid | input | 7 | ASID of the translation |
| fill_vpn | input | 20 | Virtual page number (virtual address bits [31:12]) |
| fill_pfn | input | PFN_W | Frame number to store |
| fill_perm | input | PERM_W | Permissions to store |
| inv_en | input | 1 | Invalidation command valid this cycle |
| inv_cmd | input | 32 | Invalidation command word |

## Verification
The bench runs a 7-bit-ASID instance and a 2-bit-ASID instance side by side on the same stimulus. It compares both against arithmetic models, after directed sequences and after a long run of pseudo-random fills, commands and changes to the line count. Keys are drawn from two sections, two groups and ASIDs that alias in the narrow build, so collisions are frequent.

The corner cases it targets are these. It checks that the wrap point of the replacement pointer follows the active count; a design that got this wrong would evict lines outside service or leave some lines never used. It checks that a refill of a resident key does not allocate a duplicate; a design that got this wrong would produce two hits. It uses reserved match type 1; a design that got this wrong would clear lines. It checks the position of the ASID field in each build; a design that got this wrong would clear the wrong context. It looks up a line in the same cycle as the command that clears it; a design that got this wrong would return a stale frame.

// File: rtl/asid_tlb_pkg.sv
`timescale 1ns/1ps
package asid_tlb_pkg;

  localparam int VPN_W   = 20;
  localparam int SEC_LSB = 10;
  localparam int GRP_LSB = 2;
  localparam int ASID_MAX_W = 7;

  typedef enum logic [1:0] {
    INV_ALL     = 2'd0,
    INV_NONE    = 2'd1,
    INV_SECTION = 2'd2,
    INV_GROUP   = 2'd3
  } inv_kind_e;

  typedef struct packed {
    logic                   active;
    inv_kind_e              kind;
    logic                   asid_en;
    logic [ASID_MAX_W-1:0]  asid;
    logic [VPN_W-1:0]       vpn;
  } inv_req_t;

endpackage

// File: rtl/tlb_inv_decode.sv
`timescale 1ns/1ps
module tlb_inv_decode
  import asid_tlb_pkg::*;
#(
  parameter bit NARROW_ASID = 1'b0
) (
  input  logic        inv_en,
  input  logic [31:0] inv_cmd,
  output inv_req_t    req
);

  logic [ASID_MAX_W-1:0] cmd_asid;

  generate
    if (NARROW_ASID) begin : g_narrow
      assign cmd_asid = {{(ASID_MAX_W-2){1'b0}}, inv_cmd[30:29]};
    end else begin : g_wide
      assign cmd_asid = inv_cmd[30:24];
    end
  endgenerate

  always_comb begin
    req.active  = inv_en;
    req.kind    = inv_kind_e'(inv_cmd[1:0]);
    req.asid_en = inv_cmd[31];
    req.asid    = cmd_asid;
    req.vpn     = inv_cmd[VPN_W-1:0];
  end

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^inv_cmd;

endmodule

// File: rtl/tlb_line.sv
`timescale 1ns/1ps
module tlb_line
  import asid_tlb_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int AW     = 7,
  parameter int PFN_W  = 20,
  parameter int PERM_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  active_cnt,
  input  logic [AW-1:0]     lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  inv_req_t          inv_req,
  input  logic              fill_en,
  input  logic              fill_we,
  input  logic [AW-1:0]     fill_asid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  output logic              in_use,
  output logic              lk_match,
  output logic              inv_match,
  output logic              fill_same,
  output logic [PFN_W-1:0]  pfn,
  output logic [PERM_W-1:0] perm
);

  localparam logic [CNT_W-1:0] MY_IDX = CNT_W'(IDX);

  logic              valid_q, valid_d;
  logic [AW-1:0]     asid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PFN_W-1:0]  pfn_q;
  logic [PERM_W-1:0] perm_q;
  logic              kind_hit;
  logic              asid_ok;

  assign in_use = (MY_IDX < active_cnt);

  always_comb begin
    case (inv_req.kind)
      INV_ALL:     kind_hit = 1'b1;
      INV_SECTION: kind_hit = (vpn_q[VPN_W-1:SEC_LSB] == inv_req.vpn[VPN_W-1:SEC_LSB]);
      INV_GROUP:   kind_hit = (vpn_q[VPN_W-1:GRP_LSB] == inv_req.vpn[VPN_W-1:GRP_LSB]);
      default:     kind_hit = 1'b0;
    endcase
  end

  assign asid_ok   = !inv_req.asid_en || (asid_q == inv_req.asid[AW-1:0]);
  assign inv_match = inv_req.active && valid_q && kind_hit && asid_ok;
  assign fill_same = valid_q && (vpn_q == fill_vpn) && (asid_q == fill_asid);
  assign lk_match  = in_use && valid_q && (vpn_q == lk_vpn) && (asid_q == lk_asid);

  always_comb begin
    valid_d = valid_q;
    if (inv_match || (fill_en && fill_same && !fill_we)) valid_d = 1'b0;
    if (fill_we) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      asid_q <= fill_asid;
      vpn_q  <= fill_vpn;
      pfn_q  <= fill_pfn;
      perm_q <= fill_perm;
    end
  end

  assign pfn  = pfn_q;
  assign perm = perm_q;

  logic unused_inv_bits;
  assign unused_inv_bits = ^inv_req;

  // R6
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_match && !fill_we) |=> !lk_match);

  // R3
  fill_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> valid_q);

endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] active_cnt,
  input  logic             advance,
  output logic [IDX_W-1:0] victim
);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] nxt;

  assign victim = (CNT_W'(ptr_q) < active_cnt) ? ptr_q : '0;
  assign nxt    = CNT_W'(victim) + CNT_W'(1);

  always_comb begin
    ptr_d = ptr_q;
    if (advance) ptr_d = (nxt >= active_cnt) ? '0 : IDX_W'(nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= ptr_d;
  end

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && active_cnt != '0) |=> (CNT_W'(ptr_q) < $past(active_cnt)));

endmodule

// File: rtl/asid_tlb.sv
`timescale 1ns/1ps
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter bit NARROW_ASID = 1'b0,
  parameter int PFN_W       = 20,
  parameter int PERM_W      = 3,
  localparam int CNT_W      = $clog2(NUM_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_active,
  input  logic [6:0]        lk_asid,
  input  logic [31:0]       lk_vaddr,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_en,
  input  logic [6:0]        fill_asid,
  input  logic [19:0]       fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_en,
  input  logic [31:0]       inv_cmd
);

  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int AW    = NARROW_ASID ? 2 : 7;

  logic [CNT_W-1:0]     act_eff;
  inv_req_t             inv_req;
  logic [NUM_LINES-1:0] in_use_v, lk_match_v, inv_match_v, fill_same_v;
  logic [NUM_LINES-1:0] hit_vec, act_match, vic_dec, fill_sel, fill_we_v;
  logic [PFN_W-1:0]     pfn_a  [NUM_LINES];
  logic [PERM_W-1:0]    perm_a [NUM_LINES];
  logic [IDX_W-1:0]     victim;
  logic                 have_match, advance;

  assign act_eff = (cfg_active > CNT_W'(NUM_LINES)) ? CNT_W'(NUM_LINES) : cfg_active;

  tlb_inv_decode #(.NARROW_ASID(NARROW_ASID)) u_dec (
    .inv_en  (inv_en),
    .inv_cmd (inv_cmd),
    .req     (inv_req)
  );

  tlb_victim #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_cnt (act_eff),
    .advance    (advance),
    .victim     (victim)
  );

  generate
    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
      tlb_line #(
        .IDX(gi), .AW(AW), .PFN_W(PFN_W), .PERM_W(PERM_W), .CNT_W(CNT_W)
      ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_cnt (act_eff),
        .lk_asid    (lk_asid[AW-1:0]),
        .lk_vpn     (lk_vaddr[31:12]),
        .inv_req    (inv_req),
        .fill_en    (fill_en),
        .fill_we    (fill_we_v[gi]),
        .fill_asid  (fill_asid[AW-1:0]),
        .fill_vpn   (fill_vpn),
        .fill_pfn   (fill_pfn),
        .fill_perm  (fill_perm),
        .in_use     (in_use_v[gi]),
        .lk_match   (lk_match_v[gi]),
        .inv_match  (inv_match_v[gi]),
        .fill_same  (fill_same_v[gi]),
        .pfn        (pfn_a[gi]),
        .perm       (perm_a[gi])
      );
    end
  endgenerate

  // Fill target: resident key in service first, else the round-robin victim.
  always_comb begin
    act_match  = fill_same_v & in_use_v;
    have_match = |act_match;
    vic_dec    = '0;
    if (!have_match && act_eff != '0) vic_dec[victim] = 1'b1;
    fill_sel   = have_match ? act_match : vic_dec;
    fill_we_v  = {NUM_LINES{fill_en}} & fill_sel;
    advance    = fill_en && !have_match && (act_eff != '0);
  end

  // Lookup: lines being cleared this cycle are masked out.
  assign hit_vec = lk_match_v & ~inv_match_v;
  assign lk_hit  = |hit_vec;

  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (hit_vec[i]) begin
        lk_pfn  = lk_pfn  | pfn_a[i];
        lk_perm = lk_perm | perm_a[i];
      end
    end
  end

  logic unused_top_bits;
  assign unused_top_bits = ^{lk_vaddr[11:0], lk_asid, fill_asid};

  // R4
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R4
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_same_v & in_use_v));

  // R11
  flush_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && inv_cmd[1:0] == 2'b00 && !inv_cmd[31]) |-> !lk_hit);

endmodule

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;

  logic        clk;
  logic        rst_n;
  logic [3:0]  cfg_active;
  logic [6:0]  lk_asid;
  logic [31:0] lk_vaddr;
  logic        fill_en;
  logic [6:0]  fill_asid;
  logic [19:0] fill_vpn;
  logic [19:0] fill_pfn;
  logic [2:0]  fill_perm;
  logic        inv_en;
  logic [31:0] inv_cmd;

  logic        w_hit, n_hit;
  logic [19:0] w_pfn, n_pfn;
  logic [2:0]  w_perm, n_perm;

  int total = 0;
  int fails = 0;

  // models: index 0 = 7-bit ASID build, 1 = 2-bit ASID build
  bit          mv [2][8];
  logic [6:0]  ma [2][8];
  logic [19:0] mt [2][8];
  logic [19:0] mf [2][8];
  logic [2:0]  mp [2][8];
  int          mptr [2];
  int          act;
  logic [15:0] lf;

  asid_tlb #(.NUM_LINES(8), .NARROW_ASID(1'b0)) i_asid_tlb (
    .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active),
    .lk_asid(lk_asid), .lk_vaddr(lk_vaddr),
    .lk_hit(w_hit), .lk_pfn(w_pfn), .lk_perm(w_perm),
    .fill_en(fill_en), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .inv_en(inv_en), .inv_cmd(inv_cmd)
  );

  asid_tlb #(.NUM_LINES(8), .NARROW_ASID(1'b1)) i_asid_tlb_n (
    .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active),
    .lk_asid(lk_asid), .lk_vaddr(lk_vaddr),
    .lk_hit(n_hit), .lk_pfn(n_pfn), .lk_perm(n_perm),
    .fill_en(fill_en), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .inv_en(inv_en), .inv_cmd(inv_cmd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [6:0] msk(int m);
    return (m != 0) ? 7'h03 : 7'h7f;
  endfunction

  function automatic int act_eff();
    return (act > 8) ? 8 : act;
  endfunction

  function automatic bit minv(int m, int i, logic [31:0] cmd);
    bit k;
    logic [6:0] ca;
    if (!mv[m][i]) return 1'b0;
    case (cmd[1:0])
      2'd0:    k = 1'b1;
      2'd1:    k = 1'b0;
      2'd2:    k = (mt[m][i][19:10] == cmd[19:10]);
      default: k = (mt[m][i][19:2] == cmd[19:2]);
    endcase
    ca = (m != 0) ? {5'b0, cmd[30:29]} : cmd[30:24];
    if (cmd[31] && ma[m][i] != ca) k = 1'b0;
    return k;
  endfunction

  function automatic logic [23:0] mlook(int m, logic [6:0] asid, logic [19:0] vpn,
                                        bit inv_on, logic [31:0] cmd);
    for (int i = 0; i < act_eff(); i++) begin
      if (mv[m][i] && mt[m][i] == vpn && ma[m][i] == (asid & msk(m)) &&
          !(inv_on && minv(m, i, cmd)))
        return {1'b1, mf[m][i], mp[m][i]};
    end
    return 24'h0;
  endfunction

  task automatic mfill(int m, logic [6:0] asid, logic [19:0] vpn,
                       logic [19:0] pfn, logic [2:0] perm);
    int a;
    int tgt;
    int v;
    logic [6:0] am;
    a  = act_eff();
    tgt = -1;
    am = asid & msk(m);
    for (int i = 0; i < a; i++)
      if (mv[m][i] && mt[m][i] == vpn && ma[m][i] == am) tgt = i;
    if (tgt < 0 && a > 0) begin
      v = (mptr[m] < a) ? mptr[m] : 0;
      mptr[m] = (v + 1 >= a) ? 0 : v + 1;
      tgt = v;
    end
    for (int i = 0; i < 8; i++)
      if (i != tgt && mv[m][i] && mt[m][i] == vpn && ma[m][i] == am) mv[m][i] = 1'b0;
    if (tgt >= 0) begin
      mv[m][tgt] = 1'b1;
      ma[m][tgt] = am;
      mt[m][tgt] = vpn;
      mf[m][tgt] = pfn;
      mp[m][tgt] = perm;
    end
  endtask

  task automatic chk(string req, string tag, logic [23:0] actual, logic [23:0] expect_v);
    total++;
    if (actual !== expect_v) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, tag, actual, expect_v);
    end
  endtask

  // called in the low phase, inputs already settled except the lookup key
  task automatic probe(string req, logic [6:0] asid, logic [19:0] vpn, logic [11:0] off);
    logic [23:0] e0, e1;
    lk_asid  = asid;
    lk_vaddr = {vpn, off};
    #1;
    e0 = mlook(0, asid, vpn, inv_en, inv_cmd);
    e1 = mlook(1, asid, vpn, inv_en, inv_cmd);
    chk(req, "wide",   {w_hit, w_pfn, w_perm}, e0);
    chk(req, "narrow", {n_hit, n_pfn, n_perm}, e1);
  endtask

  task automatic probe_cyc(string req, logic [6:0] asid, logic [19:0] vpn);
    @(negedge clk);
    fill_en = 1'b0;
    inv_en  = 1'b0;
    probe(req, asid, vpn, 12'h5a3);
  endtask

  task automatic fill_op(logic [6:0] asid, logic [19:0] vpn, logic [19:0] pfn, logic [2:0] perm);
    @(negedge clk);
    inv_en    = 1'b0;
    fill_en   = 1'b1;
    fill_asid = asid;
    fill_vpn  = vpn;
    fill_pfn  = pfn;
    fill_perm = perm;
    mfill(0, asid, vpn, pfn, perm);
    mfill(1, asid, vpn, pfn, perm);
  endtask

  task automatic inv_op(logic [31:0] cmd, bit sp, logic [6:0] asid, logic [19:0] vpn, string req);
    @(negedge clk);
    fill_en = 1'b0;
    inv_en  = 1'b1;
    inv_cmd = cmd;
    if (sp) probe(req, asid, vpn, 12'h010);
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 8; i++)
        if (minv(m, i, cmd)) mv[m][i] = 1'b0;
  endtask

  task automatic cfg_op(int v);
    @(negedge clk);
    fill_en    = 1'b0;
    inv_en     = 1'b0;
    cfg_active = 4'(v);
    act        = v;
  endtask

  task automatic check_all(string req);
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 8; i++)
        probe_cyc(req, ma[m][i], mt[m][i]);
  endtask

  function automatic logic [19:0] pat_vpn(int i);
    return {10'(i >> 2), 8'((i >> 1) & 1), 2'(i & 1)};
  endfunction

  function automatic logic [6:0] pat_asid(int i);
    return ((i & 1) != 0) ? 7'd5 : 7'd1;
  endfunction

  task automatic refill_pattern();
    for (int i = 0; i < 8; i++)
      fill_op(pat_asid(i), pat_vpn(i), 20'h30000 + 20'(i * 7), 3'(7 - i));
  endtask

  task automatic step_lfsr();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  function automatic logic [6:0] rnd_asid(logic [1:0] s);
    case (s)
      2'd0:    return 7'd0;
      2'd1:    return 7'd1;
      2'd2:    return 7'd5;
      default: return 7'd2;
    endcase
  endfunction

  function automatic logic [19:0] rnd_vpn(logic [15:0] r);
    return (20'(r[9]) << 10) | (20'(r[10]) << 2) | 20'(r[12:11]);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #500000;
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cfg_active = 4'd8;
    act = 8;
    lk_asid = '0; lk_vaddr = '0;
    fill_en = 1'b0; fill_asid = '0; fill_vpn = '0; fill_pfn = '0; fill_perm = '0;
    inv_en = 1'b0; inv_cmd = '0;
    lf = 16'hACE1;
    for (int m = 0; m < 2; m++) begin
      mptr[m] = 0;
      for (int i = 0; i < 8; i++) begin
        mv[m][i] = 1'b0; ma[m][i] = '0; mt[m][i] = '0; mf[m][i] = '0; mp[m][i] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: nothing resident after reset
    probe_cyc("R1", 7'd0, 20'h00000);
    probe_cyc("R1", 7'd3, 20'h12345);

    // R2: fill all lines with distinct sections, then look each up
    for (int i = 0; i < 8; i++)
      fill_op(7'(i % 3), (20'h00400 * 20'(i)) + 20'(i), 20'hA0000 + 20'(i * 17), 3'(i));
    check_all("R2");
    probe_cyc("R2", 7'd1, 20'h00000);
    probe_cyc("R2", 7'd0, 20'h00401);

    // R3: next allocation evicts line 0
    fill_op(7'd0, 20'hFFFFF, 20'h11111, 3'd5);
    check_all("R3");
    probe_cyc("R3", 7'd0, 20'h00000);

    // R4: refill of a resident key, then a new key lands on line 1
    fill_op(7'd0, 20'h00C03, 20'h22222, 3'd6);
    check_all("R4");
    fill_op(7'd2, 20'h55555, 20'h33333, 3'd1);
    check_all("R4");

    // R5: shrink to 4 lines, rotate within them
    cfg_op(4);
    check_all("R5");
    for (int i = 0; i < 5; i++)
      fill_op(7'd3, 20'h70000 + 20'(i), 20'h44440 + 20'(i), 3'd2);
    check_all("R5");
    inv_op(32'h0000_0000, 1'b0, 7'd0, 20'h0, "R5");
    cfg_op(8);
    check_all("R5");
    cfg_op(12);
    refill_pattern();
    check_all("R5");
    cfg_op(0);
    check_all("R5");
    fill_op(7'd1, 20'h0ABCD, 20'h12121, 3'd3);
    cfg_op(8);
    check_all("R5");

    // R6: flush everything
    refill_pattern();
    inv_op(32'h0000_0000, 1'b0, 7'd0, 20'h0, "R6");
    check_all("R6");

    // R7: section flushes, qualified then unqualified
    refill_pattern();
    inv_op(32'h8000_0000 | (32'd1 << 24) | 32'h2, 1'b0, 7'd0, 20'h0, "R7");
    check_all("R7");
    inv_op((32'd1 << 10) | 32'h2, 1'b0, 7'd0, 20'h0, "R7");
    check_all("R7");

    // R8: group flush unqualified, R10: group flush qualified by ASID 5
    refill_pattern();
    inv_op({12'h0, pat_vpn(0)} & 32'hFFFF_FFFC | 32'h3, 1'b0, 7'd0, 20'h0, "R8");
    check_all("R8");
    inv_op(32'h8000_0000 | (32'd5 << 24) | ({12'h0, pat_vpn(2)} & 32'hFFFF_FFFC) | 32'h3,
           1'b0, 7'd0, 20'h0, "R10");
    check_all("R10");

    // R9: reserved match type
    refill_pattern();
    inv_op(32'h0000_0001, 1'b0, 7'd0, 20'h0, "R9");
    inv_op(32'hFFFF_FFFD, 1'b0, 7'd0, 20'h0, "R9");
    check_all("R9");

    // R10: ASID field at [30:29] for the 2-bit build
    inv_op(32'h8000_0000 | (32'd1 << 29), 1'b0, 7'd0, 20'h0, "R10");
    check_all("R10");

    // R11: lookup during the clearing cycle
    refill_pattern();
    inv_op(({12'h0, pat_vpn(4)} & 32'hFFFF_FFFC) | 32'h3, 1'b1, pat_asid(4), pat_vpn(4), "R11");
    inv_op(32'h0000_0002, 1'b1, pat_asid(6), pat_vpn(6), "R11");
    inv_op(32'h0000_0000, 1'b1, pat_asid(7), pat_vpn(7), "R11");
    check_all("R11");

    // mixed pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      step_lfsr();
      case (lf[2:0])
        3'd0, 3'd1, 3'd2, 3'd3:
          fill_op(rnd_asid(lf[8:7]), rnd_vpn(lf), {4'h0, lf}, lf[5:3]);
        3'd4, 3'd5:
          inv_op((32'(lf[13]) << 31) | (32'(lf[4]) << 29) | (32'(rnd_asid(lf[8:7])) << 24) |
                 ({12'h0, rnd_vpn(lf)} & 32'hFFFF_FFFC) | 32'(lf[15:14]),
                 lf[6], rnd_asid(lf[1:0]), rnd_vpn({lf[3:0], lf[15:4]}), "R11 random");
        3'd6:
          cfg_op(int'(lf[5:3]) + 2);
        default: ;
      endcase
      step_lfsr();
      probe_cyc("R2 random", rnd_asid(lf[8:7]), rnd_vpn(lf));
      if ((n % 40) == 39) check_all("R3 random");
    end
    cfg_op(8);
    check_all("R5 random");

    finish_run();
  end

endmodule